// File: doc/BRIEF.md
# Manchester Serial Word Encoder

This block turns a 16-bit word held by a host into a framed Manchester bit stream for a bipolar line driver. It divides its input clock by six, exports that divided waveform, and divides again by two so that one bit-time lasts twelve input clocks. Every word opens with a three-bit-time sync character whose polarity marks it as a command word or a data word. The sixteen data bits follow, most significant first, each as a mid-bit transition. An odd parity bit closes the word.

The host never pushes data. The encoder pulls each data bit through a shift clock that it drives itself, one pulse per bit, issued one bit-time before that bit goes on the line. The line is driven through two active-low outputs, one for each sense of the line. A drive-enable input forces both outputs to their idle level without disturbing the word timing. A word starts at the first bit boundary where the transmit enable is high. If the enable is still high when a word ends, the next word follows with no gap.

Top module: `manch_word_tx`

## Requirements
- R1: `div6_out` is a square wave with a period of 6 `clk` cycles. It is high for 3 cycles and low for 3 cycles, and it is high during the first 3 cycles after reset is released.
- R2: While `rst` is high, both line outputs are high, `host_shift_clk` is low and any word in progress is abandoned. After release, the dividers restart from their first state.
- R3: One bit-time is 12 `clk` cycles and one half-bit is 6. A word begins only at the rising edge that ends every 12th cycle after reset release, so its first line level appears after edge 12·m.
- R4: `sync_sel` is captured when a word starts, and later changes have no effect on that word. With 1 (command), the line is positive for 3 half-bits and then negative for 3 half-bits. With 0 (data), the order is reversed.
- R5: After the sync character come 16 data bits, most significant first. A 1 is sent as positive in the first half-bit and negative in the second. A 0 is sent as negative, then positive.
- R6: The 20th bit-time carries a parity bit that makes the number of ones among the 16 data bits plus parity odd. It is coded the same way as a data bit.
- R7: `host_shift_clk` gives 16 pulses per word, each high for exactly one half-bit. The pulse for data bit k rises at the start of the second half of the bit-time before that bit, so the first pulse falls in the last sync bit-time. `host_sdi` is captured at the clock edge on which the pulse rises.
- R8: Positive line = `line_pos_n` low and `line_neg_n` high. Negative line = `line_pos_n` high and `line_neg_n` low. Idle = both high. Both outputs are never low together.
- R9: When `drive_en` is low, both line outputs are high in that same cycle. The word timing and the shift clock carry on unchanged, and line output resumes in step when `drive_en` returns high.
- R10: If `tx_enable` is high at the end of a word, the next word starts in the very next half-bit. Otherwise the line returns to idle.
- R11: `tx_enable` is examined only at bit boundaries. A pulse that is high only between boundaries starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder input clock, 12 cycles per bit |
| rst | input | 1 | Master reset, active high, synchronous |
| tx_enable | input | 1 | Request to send, examined at bit boundaries |
| sync_sel | input | 1 | 1 = command sync, 0 = data sync; captured at word start |
| host_sdi | input | 1 | NRZ data from the host |
| drive_en | input | 1 | Low forces both line outputs high |
| div6_out | output | 1 | Input clock divided by six |
| host_shift_clk | output | 1 | Shift clock for pulling host data |
| line_pos_n | output | 1 | Active-low drive for the positive line sense |
| line_neg_n | output | 1 | Active-low drive for the negative line sense |

## Verification
Words with the patterns A5C3, 0001, FFFF and 8000/0000 are sent. The mixed pattern catches swapped half-bits. The single low-order and single high-order ones catch reversed bit order and off-by-one fetch timing. The all-ones and all-zeros words give opposite parity from the 0001 word, which separates odd from even parity. Command and data sync are each used while `sync_sel` is flipped mid-word, and a mid-word inhibit slot, back-to-back words, a short enable pulse between boundaries and a reset in mid-word separate correct timing continuation, late capture and missing restart.

// File: rtl/manch_tx_pkg.sv
package manch_tx_pkg;
    typedef enum logic [1:0] {
        LVL_IDLE = 2'd0,
        LVL_POS  = 2'd1,
        LVL_NEG  = 2'd2
    } line_lvl_e;
endpackage

// File: rtl/mtx_timebase.sv
// Divide-by-N stage followed by a divide-by-2 stage; produces half-bit ticks.
module mtx_timebase #(
    parameter int DIV_RATIO = 6
) (
    input  logic clk,
    input  logic rst,
    output logic div_out,
    output logic half_tick,
    output logic bit_edge
);
    localparam int CW       = $clog2(DIV_RATIO);
    localparam int HIGH_CNT = DIV_RATIO / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          half;
    } tb_state_t;

    tb_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.cnt == CW'(DIV_RATIO - 1)) begin
            state_d.cnt  = '0;
            state_d.half = ~state_q.half;
        end else begin
            state_d.cnt = state_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign div_out   = (state_q.cnt < CW'(HIGH_CNT));
    assign half_tick = (state_q.cnt == CW'(DIV_RATIO - 1));
    assign bit_edge  = half_tick & state_q.half;
endmodule

// File: rtl/mtx_word_seq.sv
// Word sequencer: walks half-bit slots of sync, data and parity.
module mtx_word_seq
    import manch_tx_pkg::*;
#(
    parameter int DATA_BITS = 16,
    parameter int SYNC_HALF = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      half_tick,
    input  logic      bit_edge,
    input  logic      start_req,
    input  logic      sync_sel,
    input  logic      host_sdi,
    output line_lvl_e lvl,
    output logic      shift_clk
);
    localparam int SYNC_SLOTS  = 2 * SYNC_HALF;
    localparam int PAR_SLOT    = SYNC_SLOTS + 2 * DATA_BITS;
    localparam int LAST_SLOT   = PAR_SLOT + 1;
    localparam int FIRST_FETCH = SYNC_SLOTS - 1;
    localparam int LAST_FETCH  = PAR_SLOT - 3;
    localparam int SW          = $clog2(LAST_SLOT + 1);

    typedef struct packed {
        logic          active;
        logic [SW-1:0] slot;
        logic          cmd;
        logic          nxt_bit;
        logic          cur_bit;
        logic          par;
    } seq_state_t;

    seq_state_t    seq_d, seq_q;
    logic [SW-1:0] slot_n;

    function automatic logic is_fetch(input logic [SW-1:0] s);
        return (s >= SW'(FIRST_FETCH)) && (s <= SW'(LAST_FETCH)) && s[0];
    endfunction

    function automatic logic is_load(input logic [SW-1:0] s);
        return (s >= SW'(SYNC_SLOTS)) && (s < SW'(PAR_SLOT)) && !s[0];
    endfunction

    always_comb begin
        seq_d  = seq_q;
        slot_n = seq_q.slot + SW'(1);
        if (half_tick) begin
            if (!seq_q.active || seq_q.slot == SW'(LAST_SLOT)) begin
                if (bit_edge && start_req) begin
                    seq_d.active = 1'b1;
                    seq_d.slot   = '0;
                    seq_d.cmd    = sync_sel;
                    seq_d.par    = 1'b1;
                end else begin
                    seq_d.active = 1'b0;
                    seq_d.slot   = '0;
                end
            end else begin
                seq_d.slot = slot_n;
                if (is_fetch(slot_n)) begin
                    seq_d.nxt_bit = host_sdi;
                end
                if (is_load(slot_n)) begin
                    seq_d.cur_bit = seq_q.nxt_bit;
                    seq_d.par     = seq_q.par ^ seq_q.nxt_bit;
                end
                if (slot_n == SW'(PAR_SLOT)) begin
                    seq_d.cur_bit = seq_q.par;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    logic pos_phase;
    always_comb begin
        if (seq_q.slot < SW'(SYNC_SLOTS)) begin
            pos_phase = (seq_q.slot < SW'(SYNC_HALF)) ? seq_q.cmd : ~seq_q.cmd;
        end else begin
            pos_phase = seq_q.slot[0] ? ~seq_q.cur_bit : seq_q.cur_bit;
        end
        if (!seq_q.active) begin
            lvl = LVL_IDLE;
        end else if (pos_phase) begin
            lvl = LVL_POS;
        end else begin
            lvl = LVL_NEG;
        end
    end

    assign shift_clk = seq_q.active && is_fetch(seq_q.slot);
endmodule

// File: rtl/mtx_line_drv.sv
// Maps the line level onto the two active-low drive outputs, with gating.
module mtx_line_drv
    import manch_tx_pkg::*;
(
    input  line_lvl_e lvl,
    input  logic      drive_en,
    output logic      pos_n,
    output logic      neg_n
);
    always_comb begin
        pos_n = 1'b1;
        neg_n = 1'b1;
        if (drive_en) begin
            pos_n = (lvl != LVL_POS);
            neg_n = (lvl != LVL_NEG);
        end
    end
endmodule

// File: rtl/manch_word_tx.sv
module manch_word_tx
    import manch_tx_pkg::*;
#(
    parameter int DATA_BITS = 16,
    parameter int DIV_RATIO = 6,
    parameter int SYNC_HALF = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_enable,
    input  logic sync_sel,
    input  logic host_sdi,
    input  logic drive_en,
    output logic div6_out,
    output logic host_shift_clk,
    output logic line_pos_n,
    output logic line_neg_n
);
    logic      half_tick;
    logic      bit_edge;
    line_lvl_e seq_lvl;

    mtx_timebase #(.DIV_RATIO(DIV_RATIO)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .div_out   (div6_out),
        .half_tick (half_tick),
        .bit_edge  (bit_edge)
    );

    mtx_word_seq #(.DATA_BITS(DATA_BITS), .SYNC_HALF(SYNC_HALF)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .half_tick (half_tick),
        .bit_edge  (bit_edge),
        .start_req (tx_enable),
        .sync_sel  (sync_sel),
        .host_sdi  (host_sdi),
        .lvl       (seq_lvl),
        .shift_clk (host_shift_clk)
    );

    mtx_line_drv u_drv (
        .lvl      (seq_lvl),
        .drive_en (drive_en),
        .pos_n    (line_pos_n),
        .neg_n    (line_neg_n)
    );
endmodule

// File: rtl/manch_word_tx_chk.sv
module manch_word_tx_chk
    import manch_tx_pkg::*;
#(
    parameter int DIV_RATIO = 6
) (
    input logic      clk,
    input logic      rst,
    input logic      drive_en,
    input logic      div6_out,
    input logic      host_shift_clk,
    input logic      line_pos_n,
    input logic      line_neg_n,
    input line_lvl_e seq_lvl
);
    localparam int RW = $clog2(DIV_RATIO) + 2;

    logic          d6_prev, d6_seen, sh_prev;
    logic [RW-1:0] d6_run, sh_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            d6_prev <= 1'b1;
            d6_seen <= 1'b0;
            d6_run  <= '0;
            sh_prev <= 1'b0;
            sh_run  <= '0;
        end else begin
            d6_prev <= div6_out;
            if (div6_out && !d6_prev) begin
                d6_run  <= RW'(1);
                d6_seen <= 1'b1;
            end else begin
                d6_run <= d6_run + RW'(1);
            end
            sh_prev <= host_shift_clk;
            sh_run  <= host_shift_clk ? sh_run + RW'(1) : '0;
        end
    end

    assert_div6_period_R1: assert property (@(posedge clk) disable iff (rst)
        (div6_out && !d6_prev && d6_seen) |-> (d6_run == RW'(DIV_RATIO)));

    assert_shift_width_R7: assert property (@(posedge clk) disable iff (rst)
        (!host_shift_clk && sh_prev) |-> (sh_run == RW'(DIV_RATIO)));

    assert_shift_in_word_R7: assert property (@(posedge clk) disable iff (rst)
        host_shift_clk |-> (seq_lvl != LVL_IDLE));

    assert_never_both_low_R8: assert property (@(posedge clk) disable iff (rst)
        (line_pos_n || line_neg_n));

    assert_inhibit_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> (line_pos_n && line_neg_n));
endmodule

bind manch_word_tx manch_word_tx_chk #(.DIV_RATIO(DIV_RATIO)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .drive_en       (drive_en),
    .div6_out       (div6_out),
    .host_shift_clk (host_shift_clk),
    .line_pos_n     (line_pos_n),
    .line_neg_n     (line_neg_n),
    .seq_lvl        (seq_lvl)
);

// File: tb/tb_manch_word_tx.sv
`timescale 1ns/1ps
module tb_manch_word_tx;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst, tx_enable, sync_sel, host_sdi, drive_en;
    logic div6_out, host_shift_clk, line_pos_n, line_neg_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic [31:0] feed = '0;
    int feed_pos = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    manch_word_tx dut (
        .clk(clk), .rst(rst), .tx_enable(tx_enable), .sync_sel(sync_sel),
        .host_sdi(host_sdi), .drive_en(drive_en), .div6_out(div6_out),
        .host_shift_clk(host_shift_clk), .line_pos_n(line_pos_n),
        .line_neg_n(line_neg_n)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // host side: present the next bit after each shift pulse ends
    always @(negedge host_shift_clk) begin
        feed_pos = feed_pos + 1;
        host_sdi = (feed_pos < 32) ? feed[31 - feed_pos] : 1'b0;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_lvl(input int s, input logic [15:0] d,
                                            input logic cmd, input logic par);
        logic pos;
        if (s < 6)       pos = (s < 3) ? cmd : ~cmd;
        else if (s < 38) pos = (s % 2 == 0) ? d[15 - (s - 6) / 2] : ~d[15 - (s - 6) / 2];
        else             pos = (s == 38) ? par : ~par;
        return pos ? 2'b01 : 2'b10;
    endfunction

    function automatic string slot_tag(input int s);
        if (s < 6)  return "R4 sync";
        if (s < 38) return "R5 data";
        return "R6 parity";
    endfunction

    // walk one word from slot 0 offset 0; sample each half-bit at its middle
    task automatic run_slots(input logic [15:0] d, input logic cmd, input int inh,
                             input logic next_cmd);
        logic par = ~^d;
        for (int s = 0; s < 40; s++) begin
            drive_en = (s != inh);
            if (s == 0)  sync_sel = ~cmd;
            if (s == 39) sync_sel = next_cmd;
            repeat (3) @(negedge clk);
            begin
                logic [1:0] e = (s == inh) ? 2'b11 : exp_lvl(s, d, cmd, par);
                logic       es = (s % 2 == 1) && (s >= 5) && (s <= 35);
                if (s == inh)
                    chk({line_pos_n, line_neg_n} == e, "R9 inhibit", {line_pos_n, line_neg_n}, e);
                else
                    chk({line_pos_n, line_neg_n} == e, slot_tag(s), {line_pos_n, line_neg_n}, e);
                chk(host_shift_clk == es, "R7 shift clock", host_shift_clk, es);
                chk({line_pos_n, line_neg_n} != 2'b00, "R8 both low", 0, 1);
            end
            repeat (3) @(negedge clk);
        end
        drive_en = 1'b1;
    endtask

    task automatic wait_start(output int start);
        int n = 0;
        while ({line_pos_n, line_neg_n} == 2'b11 && n < 40) begin
            @(negedge clk);
            n++;
        end
        start = cyc;
        chk(n < 40, "R3 word started", n, 0);
        chk(start % 12 == 0, "R3 boundary alignment", start % 12, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; tx_enable = 1'b0; sync_sel = 1'b0; drive_en = 1'b1; host_sdi = 1'b0;
        repeat (3) @(negedge clk);
        chk({line_pos_n, line_neg_n} == 2'b11, "R2 idle in reset", {line_pos_n, line_neg_n}, 3);
        chk(host_shift_clk == 1'b0, "R2 shift low in reset", host_shift_clk, 0);
        rst = 1'b0;
        for (int k = 0; k < 12; k++) begin
            chk(div6_out == ((k % 6) < 3), "R1 div6 waveform", div6_out, (k % 6) < 3);
            @(negedge clk);
        end
    endtask

    task automatic t_word(input logic [15:0] d, input logic cmd, input int inh);
        int start;
        feed = {d, 16'h0}; feed_pos = 0; host_sdi = feed[31];
        sync_sel = cmd;
        tx_enable = 1'b1;
        @(negedge clk);
        wait_start(start);
        tx_enable = 1'b0;
        run_slots(d, cmd, inh, 1'b0);
        repeat (3) @(negedge clk);
        chk({line_pos_n, line_neg_n} == 2'b11, "R10 idle after word", {line_pos_n, line_neg_n}, 3);
        chk(host_shift_clk == 1'b0, "R10 shift idle after word", host_shift_clk, 0);
        repeat (12) @(negedge clk);
    endtask

    task automatic t_back_to_back();
        int start;
        feed = {16'h8000, 16'h0000}; feed_pos = 0; host_sdi = feed[31];
        sync_sel = 1'b0;
        tx_enable = 1'b1;
        @(negedge clk);
        wait_start(start);
        run_slots(16'h8000, 1'b0, -1, 1'b1);
        chk(cyc - start == 240, "R10 no gap between words", cyc - start, 240);
        chk({line_pos_n, line_neg_n} != 2'b11, "R10 second word active", {line_pos_n, line_neg_n}, 1);
        tx_enable = 1'b0;
        run_slots(16'h0000, 1'b1, -1, 1'b0);
        repeat (3) @(negedge clk);
        chk({line_pos_n, line_neg_n} == 2'b11, "R10 idle after pair", {line_pos_n, line_neg_n}, 3);
        repeat (12) @(negedge clk);
    endtask

    task automatic t_short_enable();
        while (cyc % 12 != 2) @(negedge clk);
        tx_enable = 1'b1;
        repeat (3) @(negedge clk);
        tx_enable = 1'b0;
        for (int k = 0; k < 4; k++) begin
            repeat (6) @(negedge clk);
            chk({line_pos_n, line_neg_n} == 2'b11, "R11 short enable ignored",
                {line_pos_n, line_neg_n}, 3);
        end
    endtask

    task automatic t_reset_mid();
        int start;
        feed = {16'hFFFF, 16'h0}; feed_pos = 0; host_sdi = feed[31];
        sync_sel = 1'b1;
        tx_enable = 1'b1;
        @(negedge clk);
        wait_start(start);
        tx_enable = 1'b0;
        repeat (63) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk({line_pos_n, line_neg_n} == 2'b11, "R2 reset aborts word", {line_pos_n, line_neg_n}, 3);
        chk(host_shift_clk == 1'b0, "R2 shift low after reset", host_shift_clk, 0);
        rst = 1'b0;
        for (int k = 0; k < 6; k++) begin
            chk(div6_out == (k < 3), "R1 div6 restart", div6_out, k < 3);
            @(negedge clk);
        end
        repeat (24) @(negedge clk);
        chk({line_pos_n, line_neg_n} == 2'b11, "R2 stays idle after reset", {line_pos_n, line_neg_n}, 3);
    endtask

    initial begin
        t_reset();
        t_word(16'hA5C3, 1'b1, -1);
        t_word(16'h0001, 1'b0, -1);
        t_word(16'hFFFF, 1'b1, 13);
        t_word(16'h0000, 1'b0, 8);
        t_back_to_back();
        t_short_enable();
        t_reset_mid();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule